// File: doc/BRIEF.md
# Two-Channel Time-Shared Symmetric FIR Filter

This block low-pass filters two independent sample streams with a single multiply-accumulate datapath. The datapath clock runs at twice the per-channel sample rate, so each sample period has two fast-clock slots. The first slot belongs to channel A and the second to channel B. A pair of input samples is taken once per sample period. Each channel is filtered in its own slot, and both results leave the block together with a one-cycle valid pulse.

The filter is direct form symmetric. Mirrored taps share a coefficient, so each mirrored pair is added before one multiply, and all pair products of a slot are summed in parallel. Each channel keeps its own tap history, and a history moves only in the slot of its own channel. Both channels use one fixed coefficient set, which is given as a parameter. The sum keeps full precision. It is then rounded and saturated to the output width.

Top module: `shared_fir2`

## Requirements
- R1: While `rstN` is low, `outA`, `outB` and `outValid` are 0.
- R2: After reset is released, the inputs are sampled only on the 1st, 3rd, 5th, ... rising edges. Values held on the inputs across the other edges have no effect on any output.
- R3: `outValid` is high for exactly one cycle in every two. The first pulse begins at the 3rd rising edge after reset release, and pulses repeat every second cycle after that.
- R4: With x[0] the newest sample of a channel and x[7] its oldest, the channel's output is the rounded and saturated value of sum over k of h[k]·x[k]. The coefficients are h = {-512, 1024, 6144, 9728, 9728, 6144, 1024, -512} in Q15 (default parameters: 16-bit signed data and output, 8 taps).
- R5: A sample pair taken at rising edge n appears on `outA`/`outB`, both updated together, at rising edge n+2. The outputs hold their value between updates.
- R6: The full-precision sum is rounded half up: 2^14 is added, then the sum is shifted arithmetically right by 15.
- R7: A result above 32767 gives 32767, and a result below -32768 gives -32768.
- R8: The two channels keep separate histories. An input applied only to channel A never changes `outB`, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the per-channel sample rate |
| rstN | input | 1 | Active-low synchronous reset |
| sampleA | input | 16 | Channel A input sample, signed |
| sampleB | input | 16 | Channel B input sample, signed |
| outA | output | 16 | Channel A filtered output, signed |
| outB | output | 16 | Channel B filtered output, signed |
| outValid | output | 1 | One-cycle pulse when outA/outB update |

## Verification
On the same rising edge the block takes a new sample pair and finishes channel B of the previous pair. At that edge the multiplexed datapath still reads the old channel B hold register while the register is overwritten. The bench provokes this by giving every sample period a new, distinct pair, back to back. It also drives junk values during the ignored cycle. Each output pulse is judged against a per-channel reference model of the pair taken two edges earlier.

// File: rtl/shared_fir2_pkg.sv
package shared_fir2_pkg;
  // Per-cycle strobes from sequencing control to the datapath
  typedef struct packed {
    logic capture;  // load the sample pair into the hold registers
    logic runA;     // datapath serves channel A this cycle
    logic runB;     // datapath serves channel B this cycle
    logic publish;  // move both results to the outputs
  } strobe_t;
endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import shared_fir2_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  output strobe_t stb
);
  logic slot;    // 0: capture + channel B slot, 1: channel A slot
  logic primed;  // a real pair has been captured

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot   <= 1'b0;
      primed <= 1'b0;
    end else begin
      slot <= ~slot;
      if (!slot) primed <= 1'b1;
    end
  end

  always_comb begin
    stb.capture = !slot;
    stb.runA    = slot;
    stb.runB    = !slot;
    stb.publish = !slot && primed;
  end

  // R3: a publish strobe is never followed by another in the next cycle
  a_r3_publish_gap: assert property (@(posedge clk) disable iff (!rstN)
    stb.publish |=> !stb.publish);
endmodule

// File: rtl/fir_sym_mac.sv
module fir_sym_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 16,
  parameter int TAPS   = 8,
  parameter int FRAC   = 15,
  parameter logic [TAPS/2*COEF_W-1:0] COEFS = {16'sd9728, 16'sd6144, 16'sd1024, 16'hFE00}
) (
  input  logic [TAPS-1:0][DATA_W-1:0] window,
  output logic signed [OUT_W-1:0]     y
);
  localparam int HALF   = TAPS / 2;
  localparam int PAIR_W = DATA_W + 1;
  localparam int PROD_W = PAIR_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(HALF) + 1;
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((longint'(1) <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - 1;

  logic signed [PROD_W-1:0] prod [HALF];

  // Pre-add each mirrored tap pair, then one multiply per pair
  for (genvar k = 0; k < HALF; k++) begin : g_pair
    logic signed [PAIR_W-1:0] pairSum;
    assign pairSum = PAIR_W'($signed(window[k])) + PAIR_W'($signed(window[TAPS-1-k]));
    assign prod[k] = PROD_W'(pairSum) * PROD_W'($signed(COEFS[k*COEF_W +: COEF_W]));
  end

  logic signed [ACC_W-1:0] acc, biased, scaled;

  always_comb begin
    acc = '0;
    for (int k = 0; k < HALF; k++) acc = acc + ACC_W'(prod[k]);
    biased = acc + (ACC_W'(1) <<< (FRAC - 1));
    scaled = biased >>> FRAC;
    if (scaled > MAXV)      y = MAXV[OUT_W-1:0];
    else if (scaled < MINV) y = MINV[OUT_W-1:0];
    else                    y = scaled[OUT_W-1:0];
  end
endmodule

// File: rtl/fir_datapath.sv
module fir_datapath
  import shared_fir2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 16,
  parameter int TAPS   = 8,
  parameter int FRAC   = 15,
  parameter logic [TAPS/2*COEF_W-1:0] COEFS = {16'sd9728, 16'sd6144, 16'sd1024, 16'hFE00}
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic signed [DATA_W-1:0] sampleA,
  input  logic signed [DATA_W-1:0] sampleB,
  output logic signed [OUT_W-1:0]  outA,
  output logic signed [OUT_W-1:0]  outB,
  output logic                     outValid
);
  localparam int LINE_N = TAPS - 1;

  logic [DATA_W-1:0]              holdA, holdB, curHold;
  logic [LINE_N-1:0][DATA_W-1:0]  lineA, lineB, curLine;
  logic [TAPS-1:0][DATA_W-1:0]    window;
  logic signed [OUT_W-1:0]        y, resA;

  // Shared datapath input mux: one channel per slot
  always_comb begin
    curHold = stb.runA ? holdA : holdB;
    curLine = stb.runA ? lineA : lineB;
    window  = {curLine, curHold};
  end

  fir_sym_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W),
    .TAPS(TAPS), .FRAC(FRAC), .COEFS(COEFS)
  ) uMac (
    .window(window),
    .y     (y)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdA    <= '0;
      holdB    <= '0;
      lineA    <= '0;
      lineB    <= '0;
      resA     <= '0;
      outA     <= '0;
      outB     <= '0;
      outValid <= 1'b0;
    end else begin
      if (stb.capture) begin
        holdA <= sampleA;
        holdB <= sampleB;
      end
      if (stb.runA) begin
        resA  <= y;
        lineA <= {lineA[LINE_N-2:0], holdA};
      end
      if (stb.runB) lineB <= {lineB[LINE_N-2:0], holdB};
      outValid <= stb.publish;
      if (stb.publish) begin
        outA <= resA;
        outB <= y;
      end
    end
  end

  // R8: channel B history is untouched in the channel A slot
  a_r8_lineb_hold: assert property (@(posedge clk) disable iff (!rstN)
    stb.runA |=> $stable(lineB));
  // R8: channel A history is untouched in the channel B slot
  a_r8_linea_hold: assert property (@(posedge clk) disable iff (!rstN)
    stb.runB |=> $stable(lineA));
  // R5: outputs change only together with a valid pulse
  a_r5_out_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stb.publish |=> ($stable(outA) && $stable(outB)));
  // R3: a valid pulse is one cycle wide
  a_r3_valid_gap: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
endmodule

// File: rtl/shared_fir2.sv
module shared_fir2
  import shared_fir2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 16,
  parameter int TAPS   = 8,
  parameter int FRAC   = 15,
  parameter logic [TAPS/2*COEF_W-1:0] COEFS = {16'sd9728, 16'sd6144, 16'sd1024, 16'hFE00}
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] sampleA,
  input  logic signed [DATA_W-1:0] sampleB,
  output logic signed [OUT_W-1:0]  outA,
  output logic signed [OUT_W-1:0]  outB,
  output logic                     outValid
);
  strobe_t stb;

  fir_ctrl uCtrl (
    .clk (clk),
    .rstN(rstN),
    .stb (stb)
  );

  fir_datapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W),
    .TAPS(TAPS), .FRAC(FRAC), .COEFS(COEFS)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .sampleA (sampleA),
    .sampleB (sampleB),
    .outA    (outA),
    .outB    (outB),
    .outValid(outValid)
  );
endmodule

// File: tb/shared_fir2_test.sv
module shared_fir2_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [15:0] sampleA = '0, sampleB = '0;
  logic signed [15:0] outA, outB;
  logic outValid;

  always #10 clk = ~clk;  // 50 MHz

  shared_fir2 uut (
    .clk(clk), .rstN(rstN), .sampleA(sampleA), .sampleB(sampleB),
    .outA(outA), .outB(outB), .outValid(outValid)
  );

  typedef struct {
    int    expA;
    int    expB;
    string tag;
  } item_t;

  item_t queueQ[$];
  int checks = 0, errors = 0;
  int cyc = 0, lastValid = -1;
  bit finished = 0;
  int coef[8] = '{-512, 1024, 6144, 9728, 9728, 6144, 1024, -512};
  int histA[8], histB[8];

  function automatic int filt(ref int h[8], input int x);
    longint s;
    for (int i = 7; i > 0; i--) h[i] = h[i-1];
    h[0] = x;
    s = 0;
    for (int i = 0; i < 8; i++) s += longint'(coef[i]) * h[i];
    s = (s + 16384) >>> 15;  // R6 round half up
    if (s > 32767) s = 32767;  // R7
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: at a negedge in the capture cycle; junk during the other cycle (R2)
  task automatic sendPair(int a, int b, string tag);
    item_t it;
    sampleA = 16'(a);
    sampleB = 16'(b);
    it.expA = filt(histA, a);
    it.expB = filt(histB, b);
    it.tag  = tag;
    queueQ.push_back(it);
    @(posedge clk);
    @(negedge clk);
    sampleA = 16'h7ABC;  // R2: must be ignored
    sampleB = -16'sd31000;
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid && !finished) begin
      item_t it;
      if (lastValid < 0) check(cyc == 3, "R3/R5 first valid cycle", cyc, 3);
      else check(cyc - lastValid == 2, "R3 valid spacing", cyc - lastValid, 2);
      lastValid = cyc;
      if (queueQ.size() == 0) begin
        check(0, "R3 unexpected valid", 1, 0);
      end else begin
        it = queueQ.pop_front();
        check(outA == it.expA, {it.tag, " outA"}, outA, it.expA);
        check(outB == it.expB, {it.tag, " outB"}, outB, it.expB);
      end
    end
  end

  initial begin
    #(20 * 200000);
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outA == 0, "R1 reset outA", outA, 0);
    check(outB == 0, "R1 reset outB", outB, 0);
    check(outValid == 0, "R1 reset outValid", outValid, 0);
    rstN = 1'b1;
    // R4/R8: impulse on channel A only, B silent
    sendPair(32767, 0, "R4/R8 impulseA");
    for (int i = 0; i < 8; i++) sendPair(0, 0, "R4/R8 impulseA tail");
    // R8: impulse on channel B only
    sendPair(0, -20000, "R8 impulseB");
    for (int i = 0; i < 8; i++) sendPair(0, 0, "R8 impulseB tail");
    // R6: half-way rounding (16*1024/32768 = 0.5, -0.5)
    sendPair(16, -16, "R6 round");
    for (int i = 0; i < 8; i++) sendPair(0, 0, "R6 round tail");
    // R4: steps with unity DC gain
    for (int i = 0; i < 10; i++) sendPair(12345, -7000, "R4 step");
    // R7: saturation patterns, opposite sign per channel
    for (int i = 0; i < 8; i++) begin
      int v = (i == 0 || i == 7) ? -32768 : 32767;
      int w = (i == 0 || i == 7) ? 32767 : -32768;
      sendPair(v, w, "R7 saturate");
    end
    // R4/R5: back-to-back pseudo-random pairs
    for (int i = 0; i < 60; i++)
      sendPair(int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R4/R5 random");
    repeat (2) @(posedge clk);
    #5;
    finished = 1;
    check(queueQ.size() == 0, "R5 all results delivered", queueQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule